// File: doc/BRIEF.md
# Re-triggerable Complementary PWM Generator

This block drives a complementary pair of switch outputs from a counter with a programmable period. Each cycle the high-side request opens at a programmed phase count and closes at a programmed duty count. The low side gets the complement of that request. A separately programmed dead time delays the turn-on edge of each side. A new cycle starts when the counter reaches the end of its period, or when an external restart input is seen high at a clock edge. The external input therefore shortens a cycle whenever it fires first. A typical use is a current-mode converter in which a comparator ends the off-time once the inductor current reaches zero.

All programming inputs are given in sixteenths of a clock, and the block uses only the whole-clock part. Period, duty, phase, both dead times and the blanking length are captured into shadow copies only when a cycle starts. Software can therefore change them at any time without tearing the cycle in progress. The turn-on of the high side also starts a blanking window, which is reported on its own output so that a downstream comparator can ignore switching noise. Each output pin has an enable and a polarity select, and both act at once.

Top module: `pwm_retrig_gen`

## Requirements
- R1: With the restart input held low, `soc_o` pulses for one clock every P clocks, where P is the captured whole-clock period (P of 0 or 1 gives a pulse every clock).
- R2: When `ext_rst_i` is high at a clock edge, `soc_o` is 1 in the following clock and the cycle counter starts again from zero. A full period follows unless the input fires again.
- R3: New values on the programming inputs take effect only at the next start of cycle. The cycle already running keeps its old period.
- R4: The high-side request is true while the counter C satisfies phase <= C < duty. The high side is active once the request has been true for at least `dt_hi` consecutive clocks, and it appears on the pin one clock later. With period 2000, duty 500, phase 0 and `dt_hi` 40, the high side is active for 460 clocks per period.
- R5: The low side follows the inverse request in the same way, using `dt_lo`. The high and low sides are never active together. With period 2000, duty 500 and `dt_lo` 40, the low side is active for 1460 clocks per period.
- R6: A side whose request lasts fewer clocks than its dead time never goes active.
- R7: `blank_o` goes high in the same clock in which the high side becomes active and stays high for the captured blanking length in clocks (80 clocks for a setting of 80).
- R8: A pin whose enable is 0 drives 0. When enabled, the pin drives the active state XOR its polarity bit, so a polarity bit of 1 makes the pin active-low. Both controls take effect without waiting for a cycle start.
- R9: Every programming input is in 1/16-clock units. Its low 4 bits are ignored, so a period input of (12<<4)|15 gives a 12-clock period.
- R10: While `rst_n` is low, both sides are inactive, `blank_o` and `soc_o` are 0, and the first start of cycle follows the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_rst_i | input | 1 | External cycle restart, sampled at each edge |
| per_i | input | CW+FRAC | Period in 1/16-clock units |
| duty_i | input | CW+FRAC | High-side request closing count, 1/16-clock units |
| phase_i | input | CW+FRAC | High-side request opening count, 1/16-clock units |
| dt_hi_i | input | CW+FRAC | High-side turn-on dead time, 1/16-clock units |
| dt_lo_i | input | CW+FRAC | Low-side turn-on dead time, 1/16-clock units |
| blank_len_i | input | CW+FRAC | Blanking window length, 1/16-clock units |
| en_hi_i | input | 1 | High pin enable |
| en_lo_i | input | 1 | Low pin enable |
| inv_hi_i | input | 1 | High pin polarity (1 = active low) |
| inv_lo_i | input | 1 | Low pin polarity (1 = active low) |
| pwm_hi_o | output | 1 | High-side pin |
| pwm_lo_o | output | 1 | Low-side pin |
| blank_o | output | 1 | Blanking window active |
| soc_o | output | 1 | First clock of a new cycle |

## Verification
The generator is first run with short free-running periods whose inputs carry non-zero fractional bits. This shows that the period comes from whole clocks only and that a mid-cycle register write waits for the next start of cycle. Restart pulses are then applied during the low-side on-time and during the high-side on-time, and the restart input is also held high for several clocks. These runs separate a correct immediate restart from a one-cycle-late one, and show that dead time still applies to the edges caused by a cut-short cycle. A request narrower than the dead time, checked on both sides, shows that the clamp works. The full-scale setting (period 2000, duty 500, 40-clock dead times, 80-clock blanking) checks the per-period on-time and blanking counts. Polarity and enable changes are checked at the pins.

// File: rtl/pwm_retrig_pkg.sv
// Shared constants for the re-triggerable PWM generator.
// Assumes: programming values arrive in fixed-point with FRAC fractional bits.
package pwm_retrig_pkg;
    localparam int unsigned PWM_CNT_W  = 16;  // whole-clock counter width
    localparam int unsigned PWM_FRAC_W = 4;   // fractional bits dropped at input
    localparam int unsigned PWM_NSIDE  = 2;   // complementary pair
    localparam int unsigned SIDE_HI    = 0;
    localparam int unsigned SIDE_LO    = 1;
endpackage

// File: rtl/pwm_cycle_timer.sv
// Cycle counter with shadowed programming fields.
// Starts a cycle on end of period, on the external restart, or right after
// reset. All fields are captured only at a start of cycle. It produces the
// raw high-side request from the phase and duty shadows.
// Assumes: synchronous active-low reset; inputs in 1/16-clock units.
module pwm_cycle_timer #(
    parameter int unsigned CW   = pwm_retrig_pkg::PWM_CNT_W,
    parameter int unsigned FRAC = pwm_retrig_pkg::PWM_FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_rst_i,
    input  logic [CW+FRAC-1:0]   per_i,
    input  logic [CW+FRAC-1:0]   duty_i,
    input  logic [CW+FRAC-1:0]   phase_i,
    input  logic [CW+FRAC-1:0]   dt_hi_i,
    input  logic [CW+FRAC-1:0]   dt_lo_i,
    input  logic [CW+FRAC-1:0]   blank_len_i,
    output logic                 soc_o,
    output logic                 req_o,
    output logic [CW-1:0]        dt_hi_o,
    output logic [CW-1:0]        dt_lo_o,
    output logic [CW-1:0]        blank_len_o
);
    localparam int unsigned RW      = CW + FRAC;
    localparam int unsigned NFLD    = 6;
    localparam int unsigned IX_PER  = 0;
    localparam int unsigned IX_DUTY = 1;
    localparam int unsigned IX_PH   = 2;
    localparam int unsigned IX_DTH  = 3;
    localparam int unsigned IX_DTL  = 4;
    localparam int unsigned IX_LEB  = 5;

    logic [CW-1:0] fld_in [NFLD];
    logic [CW-1:0] fld_q  [NFLD];
    logic [CW-1:0] cnt_q;
    logic          init_q;
    logic          soc_q;
    logic          eoc;
    logic          soc_next;

    // Drop the fractional bits of every programming input.
    assign fld_in[IX_PER]  = per_i[RW-1:FRAC];
    assign fld_in[IX_DUTY] = duty_i[RW-1:FRAC];
    assign fld_in[IX_PH]   = phase_i[RW-1:FRAC];
    assign fld_in[IX_DTH]  = dt_hi_i[RW-1:FRAC];
    assign fld_in[IX_DTL]  = dt_lo_i[RW-1:FRAC];
    assign fld_in[IX_LEB]  = blank_len_i[RW-1:FRAC];

    // End of period: the next count would reach the captured period.
    always_comb begin
        eoc      = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, fld_q[IX_PER]};
        soc_next = init_q | eoc | ext_rst_i;
    end

    // Counter, start flag and first-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            init_q <= 1'b1;
            soc_q  <= 1'b0;
        end else begin
            init_q <= 1'b0;
            soc_q  <= soc_next;
            cnt_q  <= soc_next ? '0 : cnt_q + 1'b1;
        end
    end

    // Shadow capture of all fields at start of cycle.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NFLD; i++) begin
            if (!rst_n)        fld_q[i] <= '0;
            else if (soc_next) fld_q[i] <= fld_in[i];
        end
    end

    // Raw high-side request and exported shadows.
    always_comb begin
        req_o       = (cnt_q >= fld_q[IX_PH]) && (cnt_q < fld_q[IX_DUTY]);
        soc_o       = soc_q;
        dt_hi_o     = fld_q[IX_DTH];
        dt_lo_o     = fld_q[IX_DTL];
        blank_len_o = fld_q[IX_LEB];
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !init_q |-> (cnt_q < fld_q[IX_PER] || cnt_q == '0));  // R1
    AST_EXT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> (soc_q && cnt_q == '0));  // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !soc_q |-> ($stable(fld_q[IX_PER]) && $stable(fld_q[IX_DUTY]) && $stable(fld_q[IX_PH])));  // R3
endmodule

// File: rtl/pwm_deadtime.sv
// Turn-on delay for one side of the complementary pair.
// Counts the consecutive clocks for which the side's request has been true.
// The side is active only once that count reaches the dead time. A request
// shorter than the dead time therefore never turns the side on.
// Assumes: synchronous active-low reset; dead time in whole clocks.
module pwm_deadtime #(
    parameter int unsigned CW = pwm_retrig_pkg::PWM_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [CW-1:0] dead_i,
    output logic          act_next_o,
    output logic          act_o
);
    logic [CW-1:0] run_q;

    // Active when the request has held for at least the dead time.
    always_comb begin
        act_next_o = req_i && (run_q >= dead_i);
    end

    // Saturating run-length counter and registered active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            act_o <= 1'b0;
        end else begin
            act_o <= act_next_o;
            if (!req_i)          run_q <= '0;
            else if (run_q != '1) run_q <= run_q + 1'b1;
        end
    end

    AST_ACT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> $past(req_i));  // R4
    AST_ZERO_DEAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && dead_i == '0) |=> act_o);  // R6
endmodule

// File: rtl/pwm_blanking.sv
// Blanking window that starts at the turn-on edge of the high side.
// Loads the captured length when the high side is about to become active,
// then counts down. The window is reported while the count is non-zero.
// Assumes: synchronous active-low reset; length in whole clocks.
module pwm_blanking #(
    parameter int unsigned CW = pwm_retrig_pkg::PWM_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on_next_i,
    input  logic          on_q_i,
    input  logic [CW-1:0] len_i,
    output logic          blank_o
);
    logic [CW-1:0] left_q;
    logic          arm;

    // Turn-on edge detection.
    always_comb begin
        arm     = on_next_i && !on_q_i;
        blank_o = (left_q != '0);
    end

    // Load on the turn-on edge, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (arm)            left_q <= len_i;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    AST_BLANK_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && len_i != '0) |=> blank_o);  // R7
    AST_BLANK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !blank_o) |=> !blank_o);  // R7
endmodule

// File: rtl/pwm_retrig_gen.sv
// Re-triggerable complementary PWM generator (top).
// Composes the cycle timer, one dead-time stage per side (generated) and the
// blanking window. Pin enable and polarity are applied combinationally.
// Assumes: synchronous active-low reset; programming in 1/16-clock units.
module pwm_retrig_gen #(
    parameter int unsigned CW   = pwm_retrig_pkg::PWM_CNT_W,
    parameter int unsigned FRAC = pwm_retrig_pkg::PWM_FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_rst_i,
    input  logic [CW+FRAC-1:0]   per_i,
    input  logic [CW+FRAC-1:0]   duty_i,
    input  logic [CW+FRAC-1:0]   phase_i,
    input  logic [CW+FRAC-1:0]   dt_hi_i,
    input  logic [CW+FRAC-1:0]   dt_lo_i,
    input  logic [CW+FRAC-1:0]   blank_len_i,
    input  logic                 en_hi_i,
    input  logic                 en_lo_i,
    input  logic                 inv_hi_i,
    input  logic                 inv_lo_i,
    output logic                 pwm_hi_o,
    output logic                 pwm_lo_o,
    output logic                 blank_o,
    output logic                 soc_o
);
    import pwm_retrig_pkg::*;

    localparam int unsigned NS = PWM_NSIDE;

    logic          req;
    logic [CW-1:0] dt_hi_s;
    logic [CW-1:0] dt_lo_s;
    logic [CW-1:0] blank_len_s;
    logic [NS-1:0] side_req;
    logic [CW-1:0] side_dead [NS];
    logic [NS-1:0] side_next;
    logic [NS-1:0] side_act;

    pwm_cycle_timer #(.CW(CW), .FRAC(FRAC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_rst_i   (ext_rst_i),
        .per_i       (per_i),
        .duty_i      (duty_i),
        .phase_i     (phase_i),
        .dt_hi_i     (dt_hi_i),
        .dt_lo_i     (dt_lo_i),
        .blank_len_i (blank_len_i),
        .soc_o       (soc_o),
        .req_o       (req),
        .dt_hi_o     (dt_hi_s),
        .dt_lo_o     (dt_lo_s),
        .blank_len_o (blank_len_s)
    );

    // Complementary requests and per-side dead times.
    always_comb begin
        side_req[SIDE_HI]  = req;
        side_req[SIDE_LO]  = !req;
        side_dead[SIDE_HI] = dt_hi_s;
        side_dead[SIDE_LO] = dt_lo_s;
    end

    for (genvar s = 0; s < NS; s++) begin : g_side
        pwm_deadtime #(.CW(CW)) u_dt (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (side_req[s]),
            .dead_i     (side_dead[s]),
            .act_next_o (side_next[s]),
            .act_o      (side_act[s])
        );
    end

    pwm_blanking #(.CW(CW)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_next_i (side_next[SIDE_HI]),
        .on_q_i    (side_act[SIDE_HI]),
        .len_i     (blank_len_s),
        .blank_o   (blank_o)
    );

    // Pin enable and polarity.
    always_comb begin
        pwm_hi_o = en_hi_i & (side_act[SIDE_HI] ^ inv_hi_i);
        pwm_lo_o = en_lo_i & (side_act[SIDE_LO] ^ inv_lo_i);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(side_act[SIDE_HI] && side_act[SIDE_LO]));  // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!side_act[SIDE_HI] && !side_act[SIDE_LO] && !blank_o && !soc_o));  // R10
endmodule

// File: tb/tb_pwm_retrig_gen.sv
module tb_pwm_retrig_gen;
    localparam int CW = 16;
    localparam int FR = 4;
    localparam int RW = CW + FR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_i = 1'b0;
    logic [RW-1:0] per_i = '0, duty_i = '0, phase_i = '0;
    logic [RW-1:0] dt_hi_i = '0, dt_lo_i = '0, blank_len_i = '0;
    logic en_hi_i = 1'b1, en_lo_i = 1'b1, inv_hi_i = 1'b0, inv_lo_i = 1'b0;
    logic pwm_hi_o, pwm_lo_o, blank_o, soc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_retrig_gen #(.CW(CW), .FRAC(FR)) dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i),
        .per_i(per_i), .duty_i(duty_i), .phase_i(phase_i),
        .dt_hi_i(dt_hi_i), .dt_lo_i(dt_lo_i), .blank_len_i(blank_len_i),
        .en_hi_i(en_hi_i), .en_lo_i(en_lo_i), .inv_hi_i(inv_hi_i), .inv_lo_i(inv_lo_i),
        .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o), .blank_o(blank_o), .soc_o(soc_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, stepped at each rising edge.
    int m_cnt, m_per, m_du, m_ph, m_dth, m_dtl, m_leb;
    int m_hrun, m_lrun, m_b;
    bit m_init, m_hq, m_lq, m_soc;
    bit r, hn, ln, sn;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_du = 0; m_ph = 0; m_dth = 0; m_dtl = 0; m_leb = 0;
            m_hrun = 0; m_lrun = 0; m_b = 0; m_init = 1; m_hq = 0; m_lq = 0; m_soc = 0;
        end else begin
            r  = (m_cnt >= m_ph) && (m_cnt < m_du);
            hn = r && (m_hrun >= m_dth);
            ln = !r && (m_lrun >= m_dtl);
            if (hn && !m_hq) m_b = m_leb;
            else if (m_b > 0) m_b = m_b - 1;
            sn = m_init || (m_cnt + 1 >= m_per) || ext_rst_i;
            m_hrun = r ? ((m_hrun < 65535) ? m_hrun + 1 : m_hrun) : 0;
            m_lrun = !r ? ((m_lrun < 65535) ? m_lrun + 1 : m_lrun) : 0;
            m_hq = hn; m_lq = ln; m_soc = sn; m_init = 0;
            if (sn) begin
                m_cnt = 0;
                m_per = int'(per_i >> FR);   m_du  = int'(duty_i >> FR);
                m_ph  = int'(phase_i >> FR); m_dth = int'(dt_hi_i >> FR);
                m_dtl = int'(dt_lo_i >> FR); m_leb = int'(blank_len_i >> FR);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        bit eh, el;
        eh = en_hi_i & (m_hq ^ inv_hi_i);
        el = en_lo_i & (m_lq ^ inv_lo_i);
        chk(soc_o === m_soc, "R1 soc_o per clock", int'(soc_o), int'(m_soc));
        chk(pwm_hi_o === eh, "R4 pwm_hi_o per clock", int'(pwm_hi_o), int'(eh));
        chk(pwm_lo_o === el, "R5 pwm_lo_o per clock", int'(pwm_lo_o), int'(el));
        chk(blank_o === (m_b != 0), "R7 blank_o per clock", int'(blank_o), int'(m_b != 0));
    end

    task automatic set_regs(input int per, input int du, input int ph,
                            input int dh, input int dl, input int lb, input int fr);
        per_i       = RW'((per << FR) | fr);
        duty_i      = RW'((du << FR) | fr);
        phase_i     = RW'((ph << FR) | fr);
        dt_hi_i     = RW'((dh << FR) | fr);
        dt_lo_i     = RW'((dl << FR) | fr);
        blank_len_i = RW'((lb << FR) | fr);
    endtask

    // From a negedge with soc_o high, count clocks to the next soc_o.
    task automatic count_to_next(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!soc_o && n < 5000);
    endtask

    task automatic wait_soc();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!soc_o && k < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, n2, hi, lo, bl;
        set_regs(20, 8, 2, 2, 3, 4, 9);
        repeat (4) @(negedge clk);
        // R10: reset state at the pins
        chk(pwm_hi_o == 0, "R10 hi in reset", int'(pwm_hi_o), 0);
        chk(pwm_lo_o == 0, "R10 lo in reset", int'(pwm_lo_o), 0);
        chk(blank_o == 0, "R10 blank in reset", int'(blank_o), 0);
        chk(soc_o == 0, "R10 soc in reset", int'(soc_o), 0);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(soc_o == 1, "R10 first soc after release", int'(soc_o), 1);

        // R1: free-running period of 20 (fractional bits set)
        count_to_next(n);
        count_to_next(n);
        chk(n == 20, "R1 period", n, 20);

        // R9: low bits ignored, (12<<4)|15
        #2 set_regs(12, 5, 1, 1, 1, 2, 15);
        count_to_next(n);
        count_to_next(n);
        chk(n == 12, "R9 period from fractional input", n, 12);

        // R3: mid-cycle write waits for next start
        #2 per_i = RW'(30 << FR);
        count_to_next(n);
        count_to_next(n2);
        chk(n == 12, "R3 running cycle keeps old period", n, 12);
        chk(n2 == 30, "R3 new period after start", n2, 30);

        // R2: single restart pulse
        repeat (5) @(negedge clk);
        #2 ext_rst_i = 1'b1;
        @(negedge clk);
        chk(soc_o == 1, "R2 restart next clock", int'(soc_o), 1);
        #2 ext_rst_i = 1'b0;
        count_to_next(n);
        chk(n == 30, "R2 full period after restart", n, 30);
        // R2: restart held high for three edges
        #2 ext_rst_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(soc_o == 1, "R2 held restart", int'(soc_o), 1);
        end
        #2 ext_rst_i = 1'b0;

        // R6: requests shorter than the dead times
        set_regs(20, 5, 2, 5, 20, 3, 0);
        wait_soc(); wait_soc(); wait_soc();
        hi = 0; lo = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            hi += int'(pwm_hi_o);
            lo += int'(pwm_lo_o);
        end
        chk(hi == 0, "R6 high clamped", hi, 0);
        chk(lo == 0, "R6 low clamped", lo, 0);

        // R8: high pin inverted, low pin disabled
        wait_soc();
        #2 set_regs(20, 5, 0, 2, 3, 0, 0);
        inv_hi_i = 1'b1;
        en_lo_i  = 1'b0;
        wait_soc(); wait_soc();
        hi = 0; lo = 0;
        for (int i = 0; i < 40; i++) begin
            hi += int'(pwm_hi_o);
            lo += int'(pwm_lo_o);
            @(negedge clk);
        end
        chk(hi == 34, "R8 inverted high pin ones", hi, 34);
        chk(lo == 0, "R8 disabled low pin", lo, 0);
        #2 inv_hi_i = 1'b0;
        en_lo_i = 1'b1;

        // R4 R5 R7: full-scale setting, one steady period
        set_regs(2000, 500, 0, 40, 40, 80, 0);
        wait_soc(); wait_soc(); wait_soc();
        hi = 0; lo = 0; bl = 0;
        for (int i = 0; i < 2000; i++) begin
            hi += int'(pwm_hi_o);
            lo += int'(pwm_lo_o);
            bl += int'(blank_o);
            @(negedge clk);
        end
        chk(soc_o == 1, "R1 period 2000", int'(soc_o), 1);
        chk(hi == 460, "R4 high on-time per period", hi, 460);
        chk(lo == 1460, "R5 low on-time per period", lo, 1460);
        chk(bl == 80, "R7 blanking length", bl, 80);

        // R2: restarts during low on-time and during high on-time
        repeat (700) @(negedge clk);
        #2 ext_rst_i = 1'b1;
        @(negedge clk);
        #2 ext_rst_i = 1'b0;
        repeat (300) @(negedge clk);
        #2 ext_rst_i = 1'b1;
        @(negedge clk);
        #2 ext_rst_i = 1'b0;
        repeat (2100) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule